// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flag Generator

This block sits beside a two-ported shared memory and watches the access strobes of both sides. It keeps one active-low interrupt line per side so that two processors can hand each other short messages. The word at the highest address belongs to the right side as its mailbox, and the word just below it belongs to the left side. When one side writes into the other side's mailbox, the owner's interrupt line falls. When the owner later reads its own mailbox, the line returns high.

Each side also has an active-low busy input, driven by contention arbitration elsewhere. While a side's busy input is low, that side can neither raise the other side's interrupt nor clear its own. A read of the other side's mailbox is a harmless look and changes nothing. The memory array and the message data are outside this block; it only sees the control strobes and addresses, sampled on a common clock.

Top module: `mbox_irq_gen`

## Requirements
- R1: After reset both interrupt outputs are high (inactive).
- R2: A left write (chip select low, write strobe low) to address 2^ADDR_W-1 drives `rgt_irq_n` low on the clock edge after the one that sampled it.
- R3: A right write to address 2^ADDR_W-2 drives `lft_irq_n` low on the clock edge after the one that sampled it.
- R4: A right read of 2^ADDR_W-1 returns `rgt_irq_n` high one clock later; a left read of 2^ADDR_W-2 returns `lft_irq_n` high one clock later.
- R5: A side reading the other side's mailbox changes neither interrupt output.
- R6: While a side's busy input is low, its write to the other mailbox leaves the other interrupt unchanged.
- R7: While a side's busy input is low, its read of its own mailbox leaves its interrupt unchanged.
- R8: A read counts only with chip select low, output enable low and write strobe high; a write counts with chip select low and write strobe low, whatever the output enable; nothing counts with chip select high.
- R9: If a set and a clear of the same interrupt are sampled in the same cycle, the interrupt goes low.
- R10: An interrupt with neither a set nor a clear sampled keeps its value; accesses to any other address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lft_cs_n | input | 1 | Left chip select, active low |
| lft_we_n | input | 1 | Left write strobe, active low |
| lft_oe_n | input | 1 | Left output enable, active low |
| lft_addr | input | ADDR_W | Left address |
| lft_busy_n | input | 1 | Left busy, active low |
| rgt_cs_n | input | 1 | Right chip select, active low |
| rgt_we_n | input | 1 | Right write strobe, active low |
| rgt_oe_n | input | 1 | Right output enable, active low |
| rgt_addr | input | ADDR_W | Right address |
| rgt_busy_n | input | 1 | Right busy, active low |
| lft_irq_n | output | 1 | Interrupt to left side, active low |
| rgt_irq_n | output | 1 | Interrupt to right side, active low |

## Verification
The bench builds the block with ADDR_W = 4, so the two mailboxes are addresses 15 and 14 of only sixteen. Random addresses then land on a mailbox about one access in eight, which brings simultaneous set and clear of one flag, busy-gated accesses and cross-mailbox peeks within reach of a few thousand random cycles, on top of the directed sequences for each rule.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;

    // Qualified mailbox events produced by one side's decoder.
    typedef struct packed {
        logic rd_own;   // reads its own mailbox, not busy
        logic wr_peer;  // writes the peer's mailbox, not busy
    } mbox_evt_t;

    // Registered state of one interrupt line.
    typedef struct packed {
        logic irq_n;
    } flag_state_t;

    localparam int unsigned SIDES = 2;

endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode
    import mbox_irq_pkg::*;
#(
    parameter int unsigned ADDR_W  = 15,
    parameter bit          OWN_TOP = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              busy_n_i,
    output mbox_evt_t         evt_o
);

    localparam logic [ADDR_W-1:0] TOP_ADDR  = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] NEXT_ADDR = {{(ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [ADDR_W-1:0] OWN_ADDR  = OWN_TOP ? TOP_ADDR  : NEXT_ADDR;
    localparam logic [ADDR_W-1:0] PEER_ADDR = OWN_TOP ? NEXT_ADDR : TOP_ADDR;

    logic is_read;
    logic is_write;
    logic hit_own;
    logic hit_peer;

    always_comb begin
        is_read   = !cs_n_i && !oe_n_i && we_n_i;
        is_write  = !cs_n_i && !we_n_i;
        hit_own   = (addr_i == OWN_ADDR);
        hit_peer  = (addr_i == PEER_ADDR);
        evt_o.rd_own  = is_read  && hit_own  && busy_n_i;
        evt_o.wr_peer = is_write && hit_peer && busy_n_i;
    end

    // R6: a busy side produces no set event
    assert_busy_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n_i |-> !evt_o.wr_peer);

    // R7: a busy side produces no clear event
    assert_busy_no_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n_i |-> !evt_o.rd_own);

    // R8: a clear event needs a full read strobe set
    assert_read_qual_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o.rd_own |-> (!cs_n_i && !oe_n_i && we_n_i));

    // R8: a set event needs a selected write
    assert_write_qual_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o.wr_peer |-> (!cs_n_i && !we_n_i));

endmodule

// File: rtl/mbox_irq_flag.sv
module mbox_irq_flag
    import mbox_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n_o
);

    flag_state_t state_d;
    flag_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (set_i) begin
            state_d.irq_n = 1'b0;
        end else if (clr_i) begin
            state_d.irq_n = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.irq_n <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_n_o = state_q.irq_n;

    // R2, R3, R9: a set always lands low, even with a clear alongside
    assert_set_lowers_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> !irq_n_o);

    // R4: a lone clear lands high
    assert_clear_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> irq_n_o);

    // R10: no event, no change
    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(irq_n_o));

endmodule

// File: rtl/mbox_irq_gen.sv
module mbox_irq_gen
    import mbox_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lft_cs_n,
    input  logic              lft_we_n,
    input  logic              lft_oe_n,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic              lft_busy_n,
    input  logic              rgt_cs_n,
    input  logic              rgt_we_n,
    input  logic              rgt_oe_n,
    input  logic [ADDR_W-1:0] rgt_addr,
    input  logic              rgt_busy_n,
    output logic              lft_irq_n,
    output logic              rgt_irq_n
);

    // Index 0 is the left side, index 1 the right side.
    logic [SIDES-1:0]             cs_n;
    logic [SIDES-1:0]             we_n;
    logic [SIDES-1:0]             oe_n;
    logic [SIDES-1:0]             busy_n;
    logic [SIDES-1:0][ADDR_W-1:0] addr;
    mbox_evt_t [SIDES-1:0]        evt;
    logic [SIDES-1:0]             irq_n;

    assign cs_n   = {rgt_cs_n,   lft_cs_n};
    assign we_n   = {rgt_we_n,   lft_we_n};
    assign oe_n   = {rgt_oe_n,   lft_oe_n};
    assign busy_n = {rgt_busy_n, lft_busy_n};
    assign addr   = {rgt_addr,   lft_addr};

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        localparam int unsigned PEER = SIDES - 1 - s;

        mbox_port_decode #(
            .ADDR_W  (ADDR_W),
            .OWN_TOP (s == 1)
        ) u_dec (
            .clk      (clk),
            .rst_n    (rst_n),
            .cs_n_i   (cs_n[s]),
            .we_n_i   (we_n[s]),
            .oe_n_i   (oe_n[s]),
            .addr_i   (addr[s]),
            .busy_n_i (busy_n[s]),
            .evt_o    (evt[s])
        );

        mbox_irq_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (evt[PEER].wr_peer),
            .clr_i   (evt[s].rd_own),
            .irq_n_o (irq_n[s])
        );
    end

    assign lft_irq_n = irq_n[0];
    assign rgt_irq_n = irq_n[1];

    // R1: both lines idle high when reset lifts
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lft_irq_n && rgt_irq_n));

    // R5: a peek at the other mailbox from both sides leaves both lines alone
    assert_peek_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt[0].wr_peer && !evt[0].rd_own && !evt[1].wr_peer && !evt[1].rd_own)
        |=> ($stable(lft_irq_n) && $stable(rgt_irq_n)));

endmodule

// File: tb/sim_mbox_irq_gen.sv
module sim_mbox_irq_gen;

    localparam int unsigned AW    = 4;
    localparam int unsigned TOPA  = (1 << AW) - 1;
    localparam int unsigned NEXTA = (1 << AW) - 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          l_cs, l_we, l_oe, l_bz;
    logic          r_cs, r_we, r_oe, r_bz;
    logic [AW-1:0] l_ad, r_ad;
    logic          l_irq, r_irq;

    int checks = 0;
    int fails  = 0;
    int exp_l  = 1;
    int exp_r  = 1;
    bit done   = 0;

    always #5 clk = ~clk;

    mbox_irq_gen #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .lft_cs_n(l_cs), .lft_we_n(l_we), .lft_oe_n(l_oe), .lft_addr(l_ad), .lft_busy_n(l_bz),
        .rgt_cs_n(r_cs), .rgt_we_n(r_we), .rgt_oe_n(r_oe), .rgt_addr(r_ad), .rgt_busy_n(r_bz),
        .lft_irq_n(l_irq), .rgt_irq_n(r_irq)
    );

    task automatic compare(input string tag);
        checks++;
        if (l_irq !== exp_l[0]) begin
            fails++;
            $display("FAIL %s lft_irq_n actual=%b expected=%0d", tag, l_irq, exp_l);
        end
        checks++;
        if (r_irq !== exp_r[0]) begin
            fails++;
            $display("FAIL %s rgt_irq_n actual=%b expected=%0d", tag, r_irq, exp_r);
        end
    endtask

    // Reference: decides set/clear per side from the sampled strobes.
    task automatic model_edge();
        bit l_rd, l_wr, r_rd, r_wr, set_l, clr_l, set_r, clr_r;
        l_rd  = !l_cs && !l_oe && l_we;
        l_wr  = !l_cs && !l_we;
        r_rd  = !r_cs && !r_oe && r_we;
        r_wr  = !r_cs && !r_we;
        set_r = l_wr && (int'(l_ad) == TOPA)  && l_bz;
        clr_r = r_rd && (int'(r_ad) == TOPA)  && r_bz;
        set_l = r_wr && (int'(r_ad) == NEXTA) && r_bz;
        clr_l = l_rd && (int'(l_ad) == NEXTA) && l_bz;
        if (set_r) exp_r = 0; else if (clr_r) exp_r = 1;
        if (set_l) exp_l = 0; else if (clr_l) exp_l = 1;
    endtask

    // Drive one cycle of stimulus at a falling edge, check one edge later.
    task automatic step(input logic lc, lw, lo, input int la, input logic lb,
                        input logic rc, rw, ro, input int ra, input logic rb,
                        input string tag);
        @(negedge clk);
        l_cs = lc; l_we = lw; l_oe = lo; l_ad = la[AW-1:0]; l_bz = lb;
        r_cs = rc; r_we = rw; r_oe = ro; r_ad = ra[AW-1:0]; r_bz = rb;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step(1, 1, 1, 0, 1, 1, 1, 1, 0, 1, tag);
    endtask

    initial begin
        l_cs = 1; l_we = 1; l_oe = 1; l_ad = '0; l_bz = 1;
        r_cs = 1; r_we = 1; r_oe = 1; r_ad = '0; r_bz = 1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1");
        idle("R1");

        // R2: left writes right mailbox
        step(0, 0, 1, TOPA, 1, 1, 1, 1, 0, 1, "R2");
        idle("R10");
        // R5: left peeks right mailbox, right peeks left mailbox
        step(0, 1, 0, TOPA, 1, 0, 1, 0, NEXTA, 1, "R5");
        // R7: right reads own mailbox while busy
        step(1, 1, 1, 0, 1, 0, 1, 0, TOPA, 0, "R7");
        // R8: right read without output enable does nothing
        step(1, 1, 1, 0, 1, 0, 1, 1, TOPA, 1, "R8");
        // R8: right read with chip select high does nothing
        step(1, 1, 1, 0, 1, 1, 1, 0, TOPA, 1, "R8");
        // R4: right reads own mailbox
        step(1, 1, 1, 0, 1, 0, 1, 0, TOPA, 1, "R4");

        // R6: right writes left mailbox while busy
        step(1, 1, 1, 0, 1, 0, 0, 1, NEXTA, 0, "R6");
        // R3: right writes left mailbox, output enable also low: still a write (R8)
        step(1, 1, 1, 0, 1, 0, 0, 0, NEXTA, 1, "R3");
        // R10: writes to other addresses
        step(0, 0, 1, 3, 1, 0, 0, 1, 5, 1, "R10");
        // R4: left reads own mailbox
        step(0, 1, 0, NEXTA, 1, 1, 1, 1, 0, 1, "R4");

        // R9: left sets right while right clears it in the same cycle
        step(0, 0, 1, TOPA, 1, 0, 1, 0, TOPA, 1, "R9");
        step(1, 1, 1, 0, 1, 0, 1, 0, TOPA, 1, "R4");
        // R9: mirror on the left flag
        step(0, 1, 0, NEXTA, 1, 0, 0, 1, NEXTA, 1, "R9");
        step(0, 1, 0, NEXTA, 1, 1, 1, 1, 0, 1, "R4");

        // R10: random traffic against the reference
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 3) != 0 ? 1'b0 : 1'b1,
                 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)),
                 int'($urandom_range(0, TOPA)),
                 $urandom_range(0, 3) != 0 ? 1'b1 : 1'b0,
                 $urandom_range(0, 3) != 0 ? 1'b0 : 1'b1,
                 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)),
                 int'($urandom_range(0, TOPA)),
                 $urandom_range(0, 3) != 0 ? 1'b1 : 1'b0,
                 "R10");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule